// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block turns a three-wire serial audio stream (bit clock, word clock, serial data) into parallel left and right samples. The three serial lines are brought into the block's own clock domain through synchronizer chains, and every rising edge of the bit clock samples one data bit. A frame is one left half followed by one right half. The word clock level tells which channel a half belongs to.

Two framings are supported. In I2S framing the most significant bit of a word follows the word-clock transition by one bit slot. In right-justified framing the least significant bit is the last slot before the next transition. The word length is 16, 20 or 24 bits, and a polarity bit swaps which word-clock level means the left channel. Samples leave the block sign-extended to 24 bits. Both outputs update together with a one-cycle valid pulse once a complete left/right pair is in hand.

Top module: `audioSerialRx`

## Requirements
- R1: While reset is asserted, leftSample and rightSample read zero and sampleValid is low.
- R2: With fmtI2s = 1, a word occupies bit slots 1 to N of a half, MSB first, where slot 0 is the first bit-clock rising edge that sees the new word-clock level. Slot 0 and the slots after N are ignored.
- R3: With fmtI2s = 0, a word is the last N bits of a half, MSB first, ending on the final bit-clock rise before the word-clock level changes. Earlier bits of the half are ignored.
- R4: With lrSwap = 0, a half sampled with wordClk high is the left channel and one sampled with wordClk low is the right channel. With lrSwap = 1 the mapping is reversed.
- R5: wordLenSel selects N. 2'b00 gives 16 bits, 2'b01 gives 20 bits and 2'b10 gives 24 bits. The reserved code 2'b11 behaves as 16 bits.
- R6: Each output sample is the N-bit word sign-extended to 24 bits: bits 23 down to N all equal bit N-1.
- R7: sampleValid is a single-cycle pulse. It is raised only when a right word is captured after a left word that has not yet been paired. A right word with no pending left word produces no pulse.
- R8: sampleValid rises 3 clock cycles after the bit-clock rising edge that completes the right word. In I2S framing that edge is slot N of the right half. In right-justified framing it is the first rise of the following half.
- R9: leftSample and rightSample change only in the cycle in which sampleValid is high.
- R10: A half that began before the first word-clock transition seen after reset is never captured.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock that oversamples the serial lines |
| rstN | input | 1 | Active-low synchronous reset |
| bitClk | input | 1 | Serial bit clock; data is taken on its rising edge |
| wordClk | input | 1 | Word clock; its level marks the channel |
| serData | input | 1 | Serial data, MSB first |
| fmtI2s | input | 1 | 1 selects I2S framing, 0 selects right-justified framing |
| lrSwap | input | 1 | 1 reverses the mapping from word-clock level to channel |
| wordLenSel | input | 2 | Word length code: 00=16, 01=20, 10=24, 11=16 |
| leftSample | output | 24 | Sign-extended left sample |
| rightSample | output | 24 | Sign-extended right sample |
| sampleValid | output | 1 | One-cycle pulse when a new left/right pair is presented |

## Verification
Each completed pair is due exactly three clock cycles after a known bit-clock rise. In I2S framing that rise is the last bit of the right word. In right-justified framing it is the first rise of the next half, because only the word-clock change closes the word. The bench drives every serial change on a falling clock edge and records the cycle number of that rise with the expected pair. When the pulse appears, it compares both the values and the elapsed cycle count. The bench also checks that no pulse comes without a queued pair, that no queued pair is left over at the end of a run, and that the outputs did not move between pulses.

// File: rtl/audioSerialRxPkg.sv
package audioSerialRxPkg;

  localparam int SAMPLE_W = 24;

  typedef enum logic [1:0] {
    WL_16  = 2'b00,
    WL_20  = 2'b01,
    WL_24  = 2'b10,
    WL_RSV = 2'b11
  } wordLen_e;

  // strobes from control to datapath, valid for one clk cycle
  typedef struct packed {
    logic bitStb;      // a bit-clock rising edge was seen
    logic dataBit;     // serial data sampled on that edge
    logic capStb;      // a complete word is to be taken
    logic capLeft;     // captured word belongs to the left channel
    logic capFromNew;  // take the word including the current bit
  } rxStrobes_t;

  function automatic int unsigned wordBits(logic [1:0] sel);
    case (wordLen_e'(sel))
      WL_20:   return 20;
      WL_24:   return 24;
      default: return 16;
    endcase
  endfunction

endpackage

// File: rtl/audioSerialRxCtrl.sv
module audioSerialRxCtrl
  import audioSerialRxPkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 6
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitClk,
  input  logic       wordClk,
  input  logic       serData,
  input  logic       fmtI2s,
  input  logic       lrSwap,
  input  logic [1:0] wordLenSel,
  output rxStrobes_t stb
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [SYNC_STAGES-1:0] bckSync;
  logic [SYNC_STAGES-1:0] lrSync;
  logic [SYNC_STAGES-1:0] datSync;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bckSync <= '0;
      lrSync  <= '0;
      datSync <= '0;
    end else begin
      bckSync <= {bckSync[SYNC_STAGES-2:0], bitClk};
      lrSync  <= {lrSync[SYNC_STAGES-2:0], wordClk};
      datSync <= {datSync[SYNC_STAGES-2:0], serData};
    end
  end

  logic bckNow, lrNow, datNow;
  assign bckNow = bckSync[SYNC_STAGES-1];
  assign lrNow  = lrSync[SYNC_STAGES-1];
  assign datNow = datSync[SYNC_STAGES-1];

  logic             bckPrev;   // bit clock one cycle ago
  logic             lrPrev;    // word clock at the previous bit rise
  logic             seen;      // at least one bit rise since reset
  logic             started;   // a word-clock transition has been seen
  logic [CNT_W-1:0] bitCnt;    // slot index of the previous bit

  logic             bckRise;
  logic             wordEdge;
  logic [CNT_W-1:0] idxNow;
  logic [CNT_W-1:0] wordLen;
  logic             i2sCap;
  logic             rjCap;

  always_comb begin
    bckRise  = bckNow & ~bckPrev;
    wordEdge = seen && (lrNow != lrPrev);
    if (wordEdge)               idxNow = '0;
    else if (bitCnt == CNT_MAX) idxNow = CNT_MAX;
    else                        idxNow = bitCnt + 1'b1;
    wordLen  = CNT_W'(wordBits(wordLenSel));
    // I2S: word ends on slot N of a half opened by a transition
    i2sCap   = fmtI2s && (started || wordEdge) && (idxNow == wordLen);
    // right-justified: word ends when the level changes
    rjCap    = !fmtI2s && wordEdge && started;

    stb.bitStb     = bckRise;
    stb.dataBit    = datNow;
    stb.capStb     = bckRise && (i2sCap || rjCap);
    stb.capLeft    = fmtI2s ? (lrNow ^ lrSwap) : (lrPrev ^ lrSwap);
    stb.capFromNew = fmtI2s;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bckPrev <= 1'b0;
      lrPrev  <= 1'b0;
      seen    <= 1'b0;
      started <= 1'b0;
      bitCnt  <= '0;
    end else begin
      bckPrev <= bckNow;
      if (bckRise) begin
        seen   <= 1'b1;
        lrPrev <= lrNow;
        bitCnt <= idxNow;
        if (wordEdge) started <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/audioSerialRxPath.sv
module audioSerialRxPath
  import audioSerialRxPkg::*;
#(
  parameter int W = SAMPLE_W
) (
  input  logic         clk,
  input  logic         rstN,
  input  rxStrobes_t   stb,
  input  logic [1:0]   wordLenSel,
  output logic [W-1:0] leftSample,
  output logic [W-1:0] rightSample,
  output logic         sampleValid
);

  logic [W-1:0] shiftReg;
  logic [W-1:0] shiftNext;
  logic [W-1:0] capSrc;
  logic [W-1:0] aligned;
  logic [W-1:0] capExt;
  logic [W-1:0] leftHold;
  logic         haveLeft;
  int unsigned  shAmt;

  always_comb begin
    shiftNext = {shiftReg[W-2:0], stb.dataBit};
    capSrc    = stb.capFromNew ? shiftNext : shiftReg;
    shAmt     = W - wordBits(wordLenSel);
    aligned   = capSrc << shAmt;
    capExt    = W'($signed(aligned) >>> shAmt);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg    <= '0;
      leftHold    <= '0;
      haveLeft    <= 1'b0;
      leftSample  <= '0;
      rightSample <= '0;
      sampleValid <= 1'b0;
    end else begin
      sampleValid <= 1'b0;
      if (stb.bitStb) shiftReg <= shiftNext;
      if (stb.capStb) begin
        if (stb.capLeft) begin
          leftHold <= capExt;
          haveLeft <= 1'b1;
        end else if (haveLeft) begin
          leftSample  <= leftHold;
          rightSample <= capExt;
          sampleValid <= 1'b1;
          haveLeft    <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/audioSerialRx.sv
module audioSerialRx
  import audioSerialRxPkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                bitClk,
  input  logic                wordClk,
  input  logic                serData,
  input  logic                fmtI2s,
  input  logic                lrSwap,
  input  logic [1:0]          wordLenSel,
  output logic [SAMPLE_W-1:0] leftSample,
  output logic [SAMPLE_W-1:0] rightSample,
  output logic                sampleValid
);

  rxStrobes_t stb;

  audioSerialRxCtrl #(.SYNC_STAGES(SYNC_STAGES), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .bitClk(bitClk), .wordClk(wordClk),
    .serData(serData), .fmtI2s(fmtI2s), .lrSwap(lrSwap),
    .wordLenSel(wordLenSel), .stb(stb)
  );

  audioSerialRxPath #(.W(SAMPLE_W)) u_path (
    .clk(clk), .rstN(rstN), .stb(stb), .wordLenSel(wordLenSel),
    .leftSample(leftSample), .rightSample(rightSample),
    .sampleValid(sampleValid)
  );

endmodule

// File: rtl/audioSerialRxChk.sv
module audioSerialRxChk
  import audioSerialRxPkg::*;
(
  input logic                clk,
  input logic                rstN,
  input logic [1:0]          wordLenSel,
  input rxStrobes_t          stb,
  input logic [SAMPLE_W-1:0] leftSample,
  input logic [SAMPLE_W-1:0] rightSample,
  input logic                sampleValid
);

  // R7: the pulse lasts one cycle
  assert_valid_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |=> !sampleValid);

  // R7: a pulse follows a right-channel capture strobe
  assert_valid_after_right_R7: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |-> $past(stb.capStb && !stb.capLeft));

  // R9: the outputs hold while no pulse is present
  assert_hold_outputs_R9: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |-> ($stable(leftSample) && $stable(rightSample)));

  // R6: 16-bit and reserved codes give bits 23..15 all equal
  assert_sext16_R6: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && wordLenSel != 2'b01 && wordLenSel != 2'b10) |->
      (($countones(leftSample[23:15]) == 0 || $countones(leftSample[23:15]) == 9) &&
       ($countones(rightSample[23:15]) == 0 || $countones(rightSample[23:15]) == 9)));

  // R6: the 20-bit code gives bits 23..19 all equal
  assert_sext20_R6: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && wordLenSel == 2'b01) |->
      (($countones(leftSample[23:19]) == 0 || $countones(leftSample[23:19]) == 5) &&
       ($countones(rightSample[23:19]) == 0 || $countones(rightSample[23:19]) == 5)));

endmodule

bind audioSerialRx audioSerialRxChk u_chk (
  .clk(clk), .rstN(rstN), .wordLenSel(wordLenSel), .stb(stb),
  .leftSample(leftSample), .rightSample(rightSample), .sampleValid(sampleValid)
);

// File: tb/audioSerialRx_tb.sv
module audioSerialRx_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        bitClk = 1'b0;
  logic        wordClk = 1'b0;
  logic        serData = 1'b0;
  logic        fmtI2s = 1'b0;
  logic        lrSwap = 1'b0;
  logic [1:0]  wordLenSel = 2'b00;
  logic [23:0] leftSample, rightSample;
  logic        sampleValid;

  audioSerialRx u_dut (
    .clk(clk), .rstN(rstN), .bitClk(bitClk), .wordClk(wordClk),
    .serData(serData), .fmtI2s(fmtI2s), .lrSwap(lrSwap),
    .wordLenSel(wordLenSel), .leftSample(leftSample),
    .rightSample(rightSample), .sampleValid(sampleValid)
  );

  always #10 clk = ~clk;

  int    cycleCnt = 0;
  int    checks = 0;
  int    bad = 0;
  bit    finished = 0;
  string segTag = "R2";

  logic [23:0] qL[$];
  logic [23:0] qR[$];
  int          qT[$];

  logic [23:0] expL, pendL, pendR;
  bit          haveL, pendRJ;
  logic [23:0] lastL, lastR;
  bit          moved;

  always @(posedge clk) cycleCnt <= cycleCnt + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic int nOf(input logic [1:0] sel);
    return (sel == 2'b01) ? 20 : (sel == 2'b10) ? 24 : 16;
  endfunction

  function automatic logic [23:0] sext(input logic [23:0] w, input int n);
    logic [23:0] r = w;
    for (int i = n; i < 24; i++) r[i] = w[n-1];
    return r;
  endfunction

  // result monitor: values, latency, hold between pulses
  always @(negedge clk) begin
    if (!rstN) begin
      lastL = '0; lastR = '0; moved = 0;
    end else if (sampleValid) begin
      if (qL.size() == 0) begin
        chk(0, "R7", "unexpected pulse", 1, 0);
      end else begin
        logic [23:0] eL, eR;
        int          t;
        eL = qL.pop_front(); eR = qR.pop_front(); t = qT.pop_front();
        chk(leftSample == eL, segTag, "left sample", 32'(leftSample), 32'(eL));
        chk(rightSample == eR, segTag, "right sample", 32'(rightSample), 32'(eR));
        chk(cycleCnt - t == 3, "R8", "pulse latency", 32'(cycleCnt - t), 3);
        chk(!moved, "R9", "outputs moved without pulse", 32'(moved), 0);
      end
      lastL = leftSample; lastR = rightSample; moved = 0;
    end else if (leftSample != lastL || rightSample != lastR) begin
      moved = 1;
    end
  end

  task automatic pushPair(input logic [23:0] l, input logic [23:0] r, input int t);
    qL.push_back(l); qR.push_back(r); qT.push_back(t);
  endtask

  // one half-frame of hLen bit slots; realWord marks a word the bench expects
  task automatic sendHalf(input bit isLeft, input logic [23:0] word,
                          input int hLen, input bit realWord);
    int   n = nOf(wordLenSel);
    logic lv = isLeft ? ~lrSwap : lrSwap;
    logic d;
    int   stamp;
    if (realWord && isLeft) begin
      expL = sext(word, n); haveL = 1;
    end
    for (int idx = 0; idx < hLen; idx++) begin
      if (fmtI2s) d = (idx >= 1 && idx <= n) ? word[n-idx] : 1'($urandom);
      else        d = (idx >= hLen - n) ? word[hLen-1-idx] : 1'($urandom);
      @(negedge clk);
      bitClk = 1'b0; wordClk = lv; serData = d;
      repeat (3) @(negedge clk);
      bitClk = 1'b1;
      stamp = cycleCnt;
      if (!fmtI2s && idx == 0 && pendRJ) begin
        pushPair(pendL, pendR, stamp); pendRJ = 0;
      end
      if (fmtI2s && realWord && !isLeft && idx == n && haveL) begin
        pushPair(expL, sext(word, n), stamp); haveL = 0;
      end
      repeat (3) @(negedge clk);
    end
    if (!fmtI2s && realWord && !isLeft && haveL) begin
      pendRJ = 1; pendL = expL; pendR = sext(word, n); haveL = 0;
    end
  endtask

  task automatic runSeg(input bit fmt, input bit swp, input logic [1:0] wl,
                        input int frames, input string tag, input bit orphan);
    int n;
    @(negedge clk);
    rstN = 1'b0; fmtI2s = fmt; lrSwap = swp; wordLenSel = wl;
    bitClk = 1'b0; wordClk = swp;
    repeat (4) @(negedge clk);
    chk(leftSample == 0 && rightSample == 0 && !sampleValid, "R1",
        "reset state", {leftSample[7:0], rightSample[7:0], 15'd0, sampleValid}, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    segTag = tag;
    qL.delete(); qR.delete(); qT.delete();
    haveL = 0; pendRJ = 0;
    n = nOf(wl);
    if (orphan) begin
      // R10: leading left half precedes any transition; R7: right has no partner
      sendHalf(1, 24'($urandom), 32, 0);
      sendHalf(0, 24'($urandom), 32, 1);
    end else begin
      sendHalf(0, 24'($urandom), 32, 0);
    end
    for (int f = 0; f < frames; f++) begin
      logic [23:0] wl0, wr0;
      wl0 = (f == 0) ? 24'hFFFFFF : (f == 1) ? 24'(1) << (n - 1) : 24'($urandom);
      wr0 = (f == 0) ? ~(24'(1) << (n - 1)) : (f == 1) ? 24'h000001 : 24'($urandom);
      sendHalf(1, wl0, n + 1 + int'($urandom % (32 - n)), 1);
      sendHalf(0, wr0, n + 1 + int'($urandom % (32 - n)), 1);
    end
    sendHalf(1, 24'($urandom), 32, 0);
    repeat (20) @(negedge clk);
    chk(qL.size() == 0, "R7", "missing pulses", 32'(qL.size()), 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    runSeg(1, 0, 2'b10, 6, "R2 R6", 0);
    runSeg(0, 0, 2'b00, 6, "R3 R6", 0);
    runSeg(1, 1, 2'b01, 6, "R2 R4", 0);
    runSeg(0, 1, 2'b10, 6, "R3 R4", 0);
    runSeg(0, 0, 2'b01, 6, "R3 R5", 0);
    runSeg(1, 0, 2'b11, 6, "R2 R5", 0);
    runSeg(0, 0, 2'b11, 6, "R3 R5", 0);
    runSeg(1, 0, 2'b00, 4, "R7 R10", 1);
    runSeg(0, 1, 2'b01, 4, "R7 R10", 1);
    for (int s = 0; s < 4; s++) begin
      bit          rf = 1'($urandom);
      bit          rs = 1'($urandom);
      logic [1:0]  rw = 2'($urandom);
      runSeg(rf, rs, rw, 5, rf ? "R2 R4 R5" : "R3 R4 R5", 0);
    end
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; bad++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

endmodule